// File: doc/BRIEF.md
# Overload Hiccup Protection Controller

This block guards the output stages of a multi-channel supply against sustained overcurrent. Each channel watches an overcurrent comparator. In dynamic mode, a channel that enters current limit may stay there for a bounded on-time. It is then switched off for a much longer off-time and retried after that, so the average power in a short circuit stays low. In continuous mode the hiccup is bypassed and the channel stays on in current limit. Each channel drives its output-enable gate and an overload status flag. It also registers the limit-select bit and hands it to the comparator.

Time is counted in milliseconds. Each channel has its own prescaler that divides the system clock down to a millisecond tick. The prescaler restarts whenever the channel changes state, so every on-window and off-window has an exact length in clock cycles: the window in milliseconds times the prescaler ratio. A shared over-temperature input and a per-channel enable override everything else and send a channel back to idle.

Top module: `ovl_hiccup_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with every enable low, all output enables, overload flags and limit-select outputs are 0.
- R2: The channel state changes on the same clock edge that samples its inputs. An idle channel whose enable is sampled high, with over-temperature low, raises its output enable after that edge. A sampled-low enable drops the output enable and the flag after the next edge.
- R3: Each limit-select output equals that channel's limit-select input as sampled at the previous clock edge.
- R4: In dynamic mode (mode input 0), the channel enters current limit at the first edge that samples overcurrent while it is running. If overcurrent is held, the output enable stays 1 for exactly ON_MS*CLK_PER_MS further edges and drops at the last of them. Other channels are not affected.
- R5: After shutdown, the output enable stays 0 for exactly OFF_MS*CLK_PER_MS edges and then returns to 1, whatever the overcurrent input does.
- R6: If overcurrent is still present at the retry, a full new on-time and off-time cycle follows.
- R7: If overcurrent clears before the on-time expires, the channel returns to normal running with the output enabled. A later fault gets a complete new on-time.
- R8: In continuous mode (mode input 1), an enabled channel keeps its output enable at 1 under any overcurrent, and its flag follows the sampled overcurrent input.
- R9: The flag is 1 while in current limit and throughout the off-time. It is 0 in normal running without overcurrent, and 0 in idle.
- R10: Over-temperature sampled high forces every output enable and flag to 0 after that edge. After it is released, a still-enabled channel restarts one edge later.
- R11: Dropping the enable during the off-time sends the channel to idle. Re-enabling turns the output on after one edge, without waiting for the rest of the off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | NUM_CH | Per-channel enable from the register block |
| dcl_i | input | 1 | Mode bit: 0 dynamic hiccup, 1 continuous limit |
| isel_i | input | NUM_CH | Per-channel current-limit select (0 low, 1 high) |
| oc_i | input | NUM_CH | Per-channel overcurrent comparator output |
| otp_i | input | 1 | Over-temperature alarm |
| out_en_o | output | NUM_CH | Per-channel output-stage enable |
| ovl_flag_o | output | NUM_CH | Per-channel overload status flag |
| lim_sel_o | output | NUM_CH | Registered limit select to the comparator |

## Verification
The assertions assume that every input is synchronous to the clock and is sampled only at rising edges. They also assume that the mode bit and over-temperature are shared by all channels. The window checks assume the prescaler ratio and the durations stay at their elaborated values. The stimulus changes inputs only on falling edges. It shortens the millisecond to four cycles so that whole hiccup cycles fit in a short run. It holds the mode bit steady within each scenario, so every bounded window the checker counts begins and ends under one mode.

// File: rtl/ovl_hiccup_pkg.sv
package ovl_hiccup_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_LIMIT = 2'd2,
    ST_OFF   = 2'd3
  } ovl_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ovl_ms_timer.sv
module ovl_ms_timer #(
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned MW         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic [MW-1:0] lim_ms_i,
  output logic          done_o
);

  localparam int unsigned PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          tick;
  logic          cnt_ce;

  assign tick   = run_i && (pre_q == PRE_LAST);
  assign cnt_ce = clr_i || run_i;

  always_comb begin
    pre_d = pre_q;
    ms_d  = ms_q;
    if (clr_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (run_i) begin
      if (tick) begin
        pre_d = '0;
        ms_d  = ms_q + MW'(1);
      end else begin
        pre_d = pre_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else if (cnt_ce) begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

  // window complete on the tick that closes the last millisecond
  assign done_o = tick && (ms_q == (lim_ms_i - MW'(1)));

endmodule

// File: rtl/ovl_hiccup_fsm.sv
module ovl_hiccup_fsm
  import ovl_hiccup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dcl_i,
  input  logic oc_i,
  input  logic otp_i,
  input  logic tmr_done_i,
  output logic tmr_clr_o,
  output logic tmr_run_o,
  output logic tmr_off_sel_o,
  output logic out_en_o,
  output logic ovl_flag_o
);

  ovl_state_e st_q, st_d;
  logic       flag_q, flag_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  st_d = ST_RUN;
      ST_RUN:   if (oc_i && !dcl_i) st_d = ST_LIMIT;
      ST_LIMIT: begin
        if (!oc_i || dcl_i)   st_d = ST_RUN;
        else if (tmr_done_i)  st_d = ST_OFF;
      end
      ST_OFF:   if (tmr_done_i) st_d = ST_RUN;
      default:  st_d = ST_IDLE;
    endcase
    if (otp_i || !en_i) st_d = ST_IDLE;
  end

  always_comb begin
    flag_d = (st_d == ST_OFF) || ((st_d != ST_IDLE) && oc_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      flag_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      flag_q <= flag_d;
    end
  end

  assign tmr_run_o     = (st_q == ST_LIMIT) || (st_q == ST_OFF);
  assign tmr_clr_o     = (st_d != st_q) || !tmr_run_o;
  assign tmr_off_sel_o = (st_q == ST_OFF);
  assign out_en_o      = (st_q == ST_RUN) || (st_q == ST_LIMIT);
  assign ovl_flag_o    = flag_q;

endmodule

// File: rtl/ovl_hiccup_ctrl.sv
module ovl_hiccup_ctrl #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned CLK_PER_MS = 100000,
  parameter int unsigned ON_MS      = 20,
  parameter int unsigned OFF_MS     = 900
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              dcl_i,
  input  logic [NUM_CH-1:0] isel_i,
  input  logic [NUM_CH-1:0] oc_i,
  input  logic              otp_i,
  output logic [NUM_CH-1:0] out_en_o,
  output logic [NUM_CH-1:0] ovl_flag_o,
  output logic [NUM_CH-1:0] lim_sel_o
);

  localparam int unsigned MW = $clog2(ovl_hiccup_pkg::max_u(ON_MS, OFF_MS) + 1);
  localparam logic [MW-1:0] ON_LIM  = MW'(ON_MS);
  localparam logic [MW-1:0] OFF_LIM = MW'(OFF_MS);

  logic [NUM_CH-1:0] sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= isel_i;
  end

  assign lim_sel_o = sel_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic          tmr_clr, tmr_run, tmr_off_sel, tmr_done;
    logic [MW-1:0] tmr_lim;

    assign tmr_lim = tmr_off_sel ? OFF_LIM : ON_LIM;

    ovl_ms_timer #(
      .CLK_PER_MS (CLK_PER_MS),
      .MW         (MW)
    ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (tmr_clr),
      .run_i    (tmr_run),
      .lim_ms_i (tmr_lim),
      .done_o   (tmr_done)
    );

    ovl_hiccup_fsm fsm_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .en_i          (en_i[c]),
      .dcl_i         (dcl_i),
      .oc_i          (oc_i[c]),
      .otp_i         (otp_i),
      .tmr_done_i    (tmr_done),
      .tmr_clr_o     (tmr_clr),
      .tmr_run_o     (tmr_run),
      .tmr_off_sel_o (tmr_off_sel),
      .out_en_o      (out_en_o[c]),
      .ovl_flag_o    (ovl_flag_o[c])
    );
  end

endmodule

// File: rtl/ovl_hiccup_chk.sv
module ovl_hiccup_chk #(
  parameter int unsigned NUM_CH  = 2,
  parameter int unsigned ON_CYC  = 2000000,
  parameter int unsigned OFF_CYC = 90000000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] en_i,
  input logic              dcl_i,
  input logic [NUM_CH-1:0] isel_i,
  input logic [NUM_CH-1:0] oc_i,
  input logic              otp_i,
  input logic [NUM_CH-1:0] out_en_o,
  input logic [NUM_CH-1:0] ovl_flag_o,
  input logic [NUM_CH-1:0] lim_sel_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [31:0] lo_cnt;
    logic [31:0] lim_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_cnt  <= '0;
        lim_cnt <= '0;
      end else begin
        if (!out_en_o[c] && en_i[c] && !otp_i) lo_cnt <= lo_cnt + 32'd1;
        else                                   lo_cnt <= '0;
        if (out_en_o[c] && ovl_flag_o[c] && !dcl_i) lim_cnt <= lim_cnt + 32'd1;
        else                                        lim_cnt <= '0;
      end
    end

    assert_lim_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lim_sel_o[c] == $past(isel_i[c])));

    assert_en_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[c] |=> (!out_en_o[c] && !ovl_flag_o[c]));

    assert_otp_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      otp_i |=> (!out_en_o[c] && !ovl_flag_o[c]));

    assert_dcl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[c] && !otp_i && dcl_i && out_en_o[c]) |=> out_en_o[c]);

    assert_clear_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[c] && !otp_i && out_en_o[c] && !oc_i[c]) |=> (out_en_o[c] && !ovl_flag_o[c]));

    assert_off_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_cnt <= OFF_CYC);

    assert_on_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lim_cnt <= ON_CYC + 1);
  end

endmodule

bind ovl_hiccup_ctrl ovl_hiccup_chk #(
  .NUM_CH  (NUM_CH),
  .ON_CYC  (ON_MS * CLK_PER_MS),
  .OFF_CYC (OFF_MS * CLK_PER_MS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .dcl_i      (dcl_i),
  .isel_i     (isel_i),
  .oc_i       (oc_i),
  .otp_i      (otp_i),
  .out_en_o   (out_en_o),
  .ovl_flag_o (ovl_flag_o),
  .lim_sel_o  (lim_sel_o)
);

// File: tb/ovl_hiccup_ctrl_tb_top.sv
`timescale 1ns/1ps
module ovl_hiccup_ctrl_tb_top;

  localparam int unsigned NCH   = 2;
  localparam int unsigned CPM   = 4;
  localparam int unsigned ONM   = 5;
  localparam int unsigned OFFM  = 12;
  localparam int unsigned N_ON  = ONM * CPM;
  localparam int unsigned N_OFF = OFFM * CPM;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] en, isel, oc;
  logic           dcl, otp;
  logic [NCH-1:0] out_en, flag, lim_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  ovl_hiccup_ctrl #(
    .NUM_CH(NCH), .CLK_PER_MS(CPM), .ON_MS(ONM), .OFF_MS(OFFM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dcl_i(dcl), .isel_i(isel),
    .oc_i(oc), .otp_i(otp), .out_en_o(out_en), .ovl_flag_o(flag),
    .lim_sel_o(lim_sel)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; en = '0; isel = '0; oc = '0; dcl = 1'b0; otp = 1'b0;
    step(3);
    check("R1", "out_en in reset", out_en, 0);
    check("R1", "flag in reset", flag, 0);
    check("R1", "lim_sel in reset", lim_sel, 0);
    rst_n = 1'b1;
    step(2);
    check("R1", "out_en after reset", out_en, 0);
    check("R1", "flag after reset", flag, 0);
  endtask

  task automatic t_enable;
    en = 2'b11;
    check("R2", "out_en before edge", out_en, 0);
    step(1);
    check("R2", "out_en one edge after enable", out_en, 2'b11);
    check("R2", "flag normal run", flag, 0);
  endtask

  task automatic t_limsel;
    isel = 2'b10;
    check("R3", "lim_sel before edge", lim_sel, 0);
    step(1);
    check("R3", "lim_sel after edge", lim_sel, 2'b10);
    isel = 2'b01;
    step(1);
    check("R3", "lim_sel swapped", lim_sel, 2'b01);
  endtask

  task automatic t_hiccup;
    oc[0] = 1'b1;
    step(N_ON);
    check("R4", "on at end of on-time", out_en[0], 1);
    check("R9", "flag in limit", flag[0], 1);
    step(1);
    check("R4", "off after on-time", out_en[0], 0);
    check("R4", "other channel unaffected", out_en[1], 1);
    check("R9", "flag in off-time", flag[0], 1);
    step(N_OFF - 1);
    check("R5", "still off before off-time ends", out_en[0], 0);
    step(1);
    check("R5", "retry after off-time", out_en[0], 1);
    step(N_ON);
    check("R6", "second on-time held", out_en[0], 1);
    step(1);
    check("R6", "second shutdown", out_en[0], 0);
    oc[0] = 1'b0;
    step(1);
    check("R9", "flag held during off-time w/o oc", flag[0], 1);
    check("R5", "off ignores oc clearing", out_en[0], 0);
    step(N_OFF - 1);
    check("R5", "retry after second off-time", out_en[0], 1);
    check("R9", "flag low in normal run", flag[0], 0);
  endtask

  task automatic t_early_clear;
    oc[0] = 1'b1;
    step(10);
    check("R9", "flag mid limit", flag[0], 1);
    oc[0] = 1'b0;
    step(1);
    check("R7", "run after early clear", out_en[0], 1);
    check("R7", "flag clears", flag[0], 0);
    oc[0] = 1'b1;
    step(N_ON);
    check("R7", "full fresh on-time", out_en[0], 1);
    step(1);
    check("R7", "off after fresh on-time", out_en[0], 0);
    oc[0] = 1'b0;
    step(N_OFF);
    check("R5", "recovered", out_en[0], 1);
  endtask

  task automatic t_dcl;
    int lows = 0;
    dcl = 1'b1;
    oc[0] = 1'b1;
    for (int i = 0; i < int'(N_ON + N_OFF + 8); i++) begin
      step(1);
      if (!out_en[0]) lows++;
    end
    check("R8", "continuous mode low cycles", lows, 0);
    check("R8", "flag follows oc high", flag[0], 1);
    oc[0] = 1'b0;
    step(1);
    check("R8", "flag follows oc low", flag[0], 0);
    dcl = 1'b0;
    step(1);
  endtask

  task automatic t_otp;
    otp = 1'b1;
    step(1);
    check("R10", "all off in otp", out_en, 0);
    otp = 1'b0;
    step(1);
    check("R10", "restart after otp", out_en, 2'b11);
    oc[0] = 1'b1;
    step(5);
    otp = 1'b1;
    step(1);
    check("R10", "otp overrides limit", out_en, 0);
    check("R10", "flag cleared by otp", flag, 0);
    oc[0] = 1'b0;
    otp = 1'b0;
    step(1);
    check("R10", "restart after otp in limit", out_en, 2'b11);
  endtask

  task automatic t_en_in_off;
    oc[0] = 1'b1;
    step(N_ON + 1);
    check("R11", "in off-time", out_en[0], 0);
    en[0] = 1'b0;
    step(1);
    check("R11", "idle output", out_en[0], 0);
    check("R2", "flag cleared by enable low", flag[0], 0);
    oc[0] = 1'b0;
    en[0] = 1'b1;
    step(1);
    check("R11", "re-enable skips off-time", out_en[0], 1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_enable();
    t_limsel();
    t_hiccup();
    t_early_clear();
    t_dcl();
    t_otp();
    t_en_in_off();
    step(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule